// File: doc/BRIEF.md
# Interrupt Controller Command Interface

This block is the programming and state-keeping side of an eight-line prioritised interrupt controller. Software talks to it through a byte-wide port with a one-bit address. A setup sequence of two, three or four words loads the vector base and the operating mode. After setup, the same port loads the line mask, issues end-of-service and priority-rotation commands, selects which register a read returns, and arms a poll read. Request lines are latched on rising edges into a pending register. A rotating priority search picks the winning line, and `int_req` is raised while that winner outranks every line still in service. An acknowledge strobe hands the winner to the processor as a vector and either records the line as in service or, in automatic end-of-service mode, retires it at once.

Every access is a single-cycle strobe that is always accepted. There is no back-pressure and no ready signal. Software must respect the setup sequence itself. If strobes coincide, a write wins over a read and a read wins over an acknowledge; the losing strobe is ignored. Read data and the acknowledge vector are registered and valid in the cycle after their strobe, and they hold their value until the next strobe of the same kind. `N_LINES` must be a power of two no larger than 8. The default is 8, which gives vector-base bits [7:3] and an empty code of 0x07. `IS_MASTER` enables the cascade-line exclusion of R13 on line `CASCADE_LINE` (default 2).

Top module: `pic_cmd_if`

## Requirements
- R1: After reset the mask, pending, in-service, vector base, priority base, all mode bits, the setup step, `mode_err`, `rd_data` and `ack_vector` are zero, and `int_req` is low.
- R2: A write to address 0 with bit 4 set starts setup. It clears all state, including pending requests and the mask, enters setup step 1, and records bit 0 as "mode word follows".
- R3: Address-1 writes follow the setup step. In step 0 the write loads the mask. In step 1 it loads the vector base with its low 3 bits cleared and goes to step 2. In step 2 it goes to step 3 if a mode word was announced, otherwise to step 0. In step 3 it sets cascade-nesting from bit 4 and automatic end-of-service from bit 1, then returns to step 0.
- R4: An address-0 write with bit 4 clear and bit 3 set is a read-control command. Bit 2 set arms the poll flag. Bit 1 set copies bit 0 into the register select (1 = in-service, 0 = pending). Bit 6 set copies bit 5 into special mask. A field whose enable bit is clear keeps its old value.
- R5: A read without poll returns, in the next cycle, the in-service register when the select is set and the pending register when it is clear (address 0), or the mask (address 1).
- R6: A rising edge on a request line sets its pending bit. The winner is the first unmasked pending line found when searching upward, with wrap-around, from the priority base. `int_req` is high exactly when a winner exists and its rank is lower than the rank of the highest line in service.
- R7: A read while poll is armed returns the winner index and clears that line's pending and in-service bits. If `int_req` is low, it returns 0x07 instead. Poll disarms after that one read.
- R8: An acknowledge with `int_req` high returns vector base OR winner and clears the winner's pending bit. In normal mode it also sets the winner's in-service bit. In automatic end-of-service mode it leaves the in-service register unchanged. An acknowledge with `int_req` low returns vector base OR 0x07.
- R9: Command codes 0 and 4 (bits 7:5 of an address-0 write with bits 4:3 clear) set rotate-on-auto-end from code bit 2. While that flag is on, an acknowledge in automatic mode sets the priority base to winner+1 mod 8. While it is off, an acknowledge leaves the priority base unchanged.
- R10: Codes 1 and 5 clear the highest-priority in-service bit, if any. Code 5 then sets the priority base to that line+1 mod 8.
- R11: Code 3 clears the in-service bit named by bits 2:0. Code 7 does the same and sets the priority base to that line+1. Code 6 sets the priority base to bits 2:0 plus 1, mod 8. Code 2 changes nothing.
- R12: With special mask on, lines already in service neither block lower lines nor win again.
- R13: With cascade-nesting on, the in-service bit of line 2 is left out of the blocking rank, so a new request on line 2 raises `int_req` while line 2 is still in service.
- R14: On a setup-start write, `mode_err` takes the value of bit 1 OR bit 3 (single or level mode, neither supported). It holds that value until the next setup-start write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | Single-cycle write strobe |
| rd_stb | input | 1 | Single-cycle read strobe |
| addr | input | 1 | Port address |
| wdata | input | 8 | Write data |
| irq_lvl | input | N_LINES | Request line levels |
| ack_stb | input | 1 | Single-cycle acknowledge strobe |
| rd_data | output | 8 | Registered read data |
| ack_vector | output | 8 | Registered acknowledge vector |
| int_req | output | 1 | Interrupt request to the processor |
| mode_err | output | 1 | Unsupported setup mode flag |

## Verification
On every cycle, the assertions check these rules:
- A setup start enters step 1 with the mask and in-service register clear, and `mode_err` follows the rejected mode bits.
- A mask write lands only in step 0.
- Poll disarms after one read, and `rd_data` holds between reads.
- `int_req` never rises without an unmasked pending line.
- A normal acknowledge adds exactly one in-service bit, and a non-specific end-of-service removes exactly one.

Only the scenarios can show which line wins under each of the eight priority bases, what the poll and acknowledge return, and how each command code moves the in-service bits and the base. The same holds for the setup word counting with and without the mode word, and for the special-mask and cascade-nesting exceptions.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;

  parameter int unsigned BYTE_W = 8;

  // write-data bit positions decoded at address 0
  localparam int unsigned B_START  = 4;
  localparam int unsigned B_CTRL   = 3;
  localparam int unsigned B_POLL   = 2;
  localparam int unsigned B_SELEN  = 1;
  localparam int unsigned B_SELV   = 0;
  localparam int unsigned B_SMMEN  = 6;
  localparam int unsigned B_SMMV   = 5;
  localparam int unsigned B_NEED4  = 0;
  localparam int unsigned B_SINGLE = 1;
  localparam int unsigned B_LEVEL  = 3;
  // mode-word bit positions
  localparam int unsigned B_NEST   = 4;
  localparam int unsigned B_AEOI   = 1;

  typedef enum logic [1:0] {
    STEP_IDLE = 2'd0,
    STEP_BASE = 2'd1,
    STEP_SKIP = 2'd2,
    STEP_MODE = 2'd3
  } init_step_e;

  typedef enum logic [2:0] {
    OP_RAEOI_OFF    = 3'd0,
    OP_EOI_TOP      = 3'd1,
    OP_NOP          = 3'd2,
    OP_EOI_LINE     = 3'd3,
    OP_RAEOI_ON     = 3'd4,
    OP_EOI_TOP_ROT  = 3'd5,
    OP_SET_BASE     = 3'd6,
    OP_EOI_LINE_ROT = 3'd7
  } op_code_e;

  typedef struct packed {
    logic aeoi;
    logic raeoi;
    logic nest;
    logic smm;
    logic rsel;
    logic poll;
  } mode_t;

endpackage

// File: rtl/pic_prio_find.sv
module pic_prio_find #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] base,
  output logic          found,
  output logic [IW-1:0] line,
  output logic [IW:0]   rank
);
  always_comb begin
    found = 1'b0;
    line  = '0;
    rank  = (IW+1)'(N);
    for (int p = N - 1; p >= 0; p--) begin
      int idx;
      idx = (int'(base) + p) % N;
      if (req[idx]) begin
        found = 1'b1;
        line  = IW'(idx);
        rank  = (IW+1)'(p);
      end
    end
  end
endmodule

// File: rtl/pic_edge_latch.sv
module pic_edge_latch #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] last_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   last_q <= '0;
    else if (clr) last_q <= '0;
    else          last_q <= lvl;
  end

  assign rise = lvl & ~last_q;
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       need4_in,
  input  logic       data_wr,
  output init_step_e step,
  output logic       load_mask,
  output logic       load_base,
  output logic       load_mode
);
  logic need4_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step    <= STEP_IDLE;
      need4_q <= 1'b0;
    end else if (start) begin
      step    <= STEP_BASE;
      need4_q <= need4_in;
    end else if (data_wr) begin
      unique case (step)
        STEP_IDLE: step <= STEP_IDLE;
        STEP_BASE: step <= STEP_SKIP;
        STEP_SKIP: step <= need4_q ? STEP_MODE : STEP_IDLE;
        STEP_MODE: step <= STEP_IDLE;
        default:   step <= STEP_IDLE;
      endcase
    end
  end

  assign load_mask = data_wr && (step == STEP_IDLE);
  assign load_base = data_wr && (step == STEP_BASE);
  assign load_mode = data_wr && (step == STEP_MODE);
endmodule

// File: rtl/pic_cmd_if.sv
module pic_cmd_if
  import pic_cmd_pkg::*;
#(
  parameter int N_LINES      = 8,
  parameter int CASCADE_LINE = 2,
  parameter int IS_MASTER    = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_stb,
  input  logic               rd_stb,
  input  logic               addr,
  input  logic [7:0]         wdata,
  input  logic [N_LINES-1:0] irq_lvl,
  input  logic               ack_stb,
  output logic [7:0]         rd_data,
  output logic [7:0]         ack_vector,
  output logic               int_req,
  output logic               mode_err
);
  localparam int IW = (N_LINES > 1) ? $clog2(N_LINES) : 1;
  localparam logic [BYTE_W-1:0] LOW_MASK = BYTE_W'(N_LINES - 1);
  localparam logic [IW-1:0]     ONE      = IW'(1);

  // architectural state
  logic [N_LINES-1:0] irr, isr, imr;
  logic [IW-1:0]      base_q;
  logic [BYTE_W-1:0]  vbase_q;
  mode_t              mode_q;

  // strobe arbitration: write > read > acknowledge
  logic do_wr, do_rd, do_ack;
  assign do_wr  = wr_stb;
  assign do_rd  = rd_stb && !wr_stb;
  assign do_ack = ack_stb && !wr_stb && !rd_stb;

  // write decode
  logic     is_start, is_ctrl, is_cmd, data_wr;
  op_code_e op;
  logic [IW-1:0] lsel;
  assign is_start = do_wr && !addr && wdata[B_START];
  assign is_ctrl  = do_wr && !addr && !wdata[B_START] && wdata[B_CTRL];
  assign is_cmd   = do_wr && !addr && !wdata[B_START] && !wdata[B_CTRL];
  assign data_wr  = do_wr && addr;
  assign op       = op_code_e'(wdata[7:5]);
  assign lsel     = wdata[IW-1:0];

  // setup sequencer
  init_step_e step;
  logic load_mask, load_base, load_mode;
  pic_init_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (is_start),
    .need4_in  (wdata[B_NEED4]),
    .data_wr   (data_wr),
    .step      (step),
    .load_mask (load_mask),
    .load_base (load_base),
    .load_mode (load_mode)
  );

  // request edge capture
  logic [N_LINES-1:0] rise;
  pic_edge_latch #(.N(N_LINES)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (is_start),
    .lvl   (irq_lvl),
    .rise  (rise)
  );

  // priority resolution
  logic [N_LINES-1:0] pend_req, svc_req;
  assign pend_req = irr & ~imr & ~({N_LINES{mode_q.smm}} & isr);

  generate
    if (IS_MASTER != 0) begin : g_cascade
      always_comb begin
        svc_req = isr;
        if (mode_q.nest) svc_req[CASCADE_LINE] = 1'b0;
        if (mode_q.smm)  svc_req = '0;
      end
    end else begin : g_plain
      assign svc_req = mode_q.smm ? '0 : isr;
    end
  endgenerate

  logic          p_found, s_found, t_found;
  logic [IW-1:0] p_line, s_line, t_line;
  logic [IW:0]   p_rank, s_rank, t_rank;

  pic_prio_find #(.N(N_LINES), .IW(IW)) u_pend (
    .req (pend_req), .base (base_q),
    .found (p_found), .line (p_line), .rank (p_rank)
  );
  pic_prio_find #(.N(N_LINES), .IW(IW)) u_svc (
    .req (svc_req), .base (base_q),
    .found (s_found), .line (s_line), .rank (s_rank)
  );
  pic_prio_find #(.N(N_LINES), .IW(IW)) u_top (
    .req (isr), .base (base_q),
    .found (t_found), .line (t_line), .rank (t_rank)
  );

  logic unused_find;
  assign unused_find = ^{s_found, s_line, t_rank};

  assign int_req = p_found && (p_rank < s_rank);

  // next-state logic
  logic [N_LINES-1:0] irr_n, isr_n, imr_n;
  logic [IW-1:0]      base_n;
  logic [BYTE_W-1:0]  vbase_n, rdata_n, ackv_n;
  mode_t              mode_n;
  logic               err_n;

  always_comb begin
    irr_n   = irr;
    isr_n   = isr;
    imr_n   = imr;
    base_n  = base_q;
    vbase_n = vbase_q;
    mode_n  = mode_q;
    err_n   = mode_err;
    rdata_n = rd_data;
    ackv_n  = ack_vector;

    if (is_start) begin
      irr_n   = '0;
      isr_n   = '0;
      imr_n   = '0;
      base_n  = '0;
      vbase_n = '0;
      mode_n  = '0;
      err_n   = wdata[B_SINGLE] | wdata[B_LEVEL];
    end else begin
      if (is_ctrl) begin
        if (wdata[B_POLL])  mode_n.poll = 1'b1;
        if (wdata[B_SELEN]) mode_n.rsel = wdata[B_SELV];
        if (wdata[B_SMMEN]) mode_n.smm  = wdata[B_SMMV];
      end

      if (is_cmd) begin
        unique case (op)
          OP_RAEOI_OFF, OP_RAEOI_ON: mode_n.raeoi = op[2];
          OP_EOI_TOP, OP_EOI_TOP_ROT: begin
            if (t_found) begin
              isr_n[t_line] = 1'b0;
              if (op == OP_EOI_TOP_ROT) base_n = t_line + ONE;
            end
          end
          OP_EOI_LINE: isr_n[lsel] = 1'b0;
          OP_EOI_LINE_ROT: begin
            isr_n[lsel] = 1'b0;
            base_n      = lsel + ONE;
          end
          OP_SET_BASE: base_n = lsel + ONE;
          default: ;
        endcase
      end

      if (load_mask) imr_n   = wdata[N_LINES-1:0];
      if (load_base) vbase_n = wdata & ~LOW_MASK;
      if (load_mode) begin
        mode_n.nest = wdata[B_NEST];
        mode_n.aeoi = wdata[B_AEOI];
      end

      if (do_rd) begin
        if (mode_q.poll) begin
          mode_n.poll = 1'b0;
          if (int_req) begin
            rdata_n       = BYTE_W'(p_line);
            irr_n[p_line] = 1'b0;
            isr_n[p_line] = 1'b0;
          end else begin
            rdata_n = LOW_MASK;
          end
        end else if (!addr) begin
          rdata_n = mode_q.rsel ? BYTE_W'(isr) : BYTE_W'(irr);
        end else begin
          rdata_n = BYTE_W'(imr);
        end
      end

      if (do_ack) begin
        if (int_req) begin
          ackv_n        = vbase_q | BYTE_W'(p_line);
          irr_n[p_line] = 1'b0;
          if (mode_q.aeoi) begin
            if (mode_q.raeoi) base_n = p_line + ONE;
          end else begin
            isr_n[p_line] = 1'b1;
          end
        end else begin
          ackv_n = vbase_q | LOW_MASK;
        end
      end

      irr_n = irr_n | rise;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr        <= '0;
      isr        <= '0;
      imr        <= '0;
      base_q     <= '0;
      vbase_q    <= '0;
      mode_q     <= '0;
      mode_err   <= 1'b0;
      rd_data    <= '0;
      ack_vector <= '0;
    end else begin
      irr        <= irr_n;
      isr        <= isr_n;
      imr        <= imr_n;
      base_q     <= base_n;
      vbase_q    <= vbase_n;
      mode_q     <= mode_n;
      mode_err   <= err_n;
      rd_data    <= rdata_n;
      ack_vector <= ackv_n;
    end
  end
endmodule

// File: rtl/pic_cmd_if_chk.sv
module pic_cmd_if_chk #(
  parameter int N_LINES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_stb,
  input logic               rd_stb,
  input logic               ack_stb,
  input logic               addr,
  input logic [7:0]         wdata,
  input logic [7:0]         rd_data,
  input logic               int_req,
  input logic               mode_err,
  input logic [N_LINES-1:0] irr,
  input logic [N_LINES-1:0] isr,
  input logic [N_LINES-1:0] imr,
  input logic [1:0]         step,
  input logic               poll_q,
  input logic               aeoi_q,
  input logic               nest_q
);
  AST_SETUP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !addr && wdata[4]) |=> (step == 2'd1 && isr == '0 && imr == '0)); // R2

  AST_ERR_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !addr && wdata[4]) |=> (mode_err == $past(wdata[1] | wdata[3]))); // R14

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && addr && step == 2'd0) |=> (imr == $past(wdata[N_LINES-1:0]))); // R3

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb || wr_stb) |=> $stable(rd_data)); // R5

  AST_POLL_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !wr_stb && poll_q) |=> !poll_q); // R7

  AST_REQ_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> ((irr & ~imr) != '0)); // R6

  AST_ACK_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_stb && !wr_stb && !rd_stb && int_req && !aeoi_q && !nest_q)
    |=> ($countones(isr) == $countones($past(isr)) + 1)); // R8

  AST_EOI_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !addr && wdata[7:3] == 5'b00100 && isr != '0)
    |=> ($countones(isr) == $countones($past(isr)) - 1)); // R10
endmodule

bind pic_cmd_if pic_cmd_if_chk #(.N_LINES(N_LINES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_stb   (wr_stb),
  .rd_stb   (rd_stb),
  .ack_stb  (ack_stb),
  .addr     (addr),
  .wdata    (wdata),
  .rd_data  (rd_data),
  .int_req  (int_req),
  .mode_err (mode_err),
  .irr      (irr),
  .isr      (isr),
  .imr      (imr),
  .step     (step),
  .poll_q   (mode_q.poll),
  .aeoi_q   (mode_q.aeoi),
  .nest_q   (mode_q.nest)
);

// File: tb/sim_pic_cmd_if.sv
`timescale 1ns/1ps
module sim_pic_cmd_if;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_stb = 1'b0, rd_stb = 1'b0, ack_stb = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] irq_lvl = '0;
  logic [7:0] rd_data, ack_vector;
  logic       int_req, mode_err;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  pic_cmd_if u0 (
    .clk (clk), .rst_n (rst_n), .wr_stb (wr_stb), .rd_stb (rd_stb),
    .addr (addr), .wdata (wdata), .irq_lvl (irq_lvl), .ack_stb (ack_stb),
    .rd_data (rd_data), .ack_vector (ack_vector), .int_req (int_req),
    .mode_err (mode_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); wr_stb = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_stb = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk); rd_stb = 1'b1; addr = a;
    @(negedge clk); rd_stb = 1'b0; v = rd_data;
  endtask

  task automatic ack(output logic [7:0] v);
    @(negedge clk); ack_stb = 1'b1;
    @(negedge clk); ack_stb = 1'b0; v = ack_vector;
  endtask

  task automatic pulse(input logic [7:0] p);
    @(negedge clk); irq_lvl = p;
    @(negedge clk); irq_lvl = '0;
    @(negedge clk);
  endtask

  task automatic setup(input logic [7:0] vb, input bit four, input logic [7:0] mw);
    wr(1'b0, four ? 8'h11 : 8'h10);
    wr(1'b1, vb);
    wr(1'b1, 8'h00);
    if (four) wr(1'b1, mw);
  endtask

  function automatic int winner(input logic [7:0] p, input int b);
    for (int k = 0; k < 8; k++) begin
      if (p[(b + k) % 8]) return (b + k) % 8;
    end
    return 7;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 int_req", int_req, 0);
    chk("R1 mode_err", mode_err, 0);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 ack_vector", ack_vector, 0);
    rd(1'b0, v); chk("R1 pending", v, 0);
    rd(1'b1, v); chk("R1 mask", v, 0);

    // R14 unsupported mode flag
    wr(1'b0, 8'h12); chk("R14 single", mode_err, 1);
    wr(1'b0, 8'h18); chk("R14 level", mode_err, 1);
    wr(1'b0, 8'h10); chk("R14 clear", mode_err, 0);

    // R2 setup clears mask and pending
    setup(8'h40, 0, 8'h00);
    wr(1'b1, 8'h33);
    pulse(8'h81);
    setup(8'h40, 0, 8'h00);
    rd(1'b1, v); chk("R2 mask cleared", v, 0);
    rd(1'b0, v); chk("R2 pending cleared", v, 0);

    // R3 word counting without and with the mode word
    wr(1'b0, 8'h10); wr(1'b1, 8'h48); wr(1'b1, 8'h00); wr(1'b1, 8'h5A);
    rd(1'b1, v); chk("R3 three-word mask", v, 8'h5A);
    wr(1'b0, 8'h11); wr(1'b1, 8'h48); wr(1'b1, 8'h00); wr(1'b1, 8'h5A);
    rd(1'b1, v); chk("R3 mode word not mask", v, 0);
    wr(1'b1, 8'h33);
    rd(1'b1, v); chk("R3 mask after four", v, 8'h33);

    // R3 / R5 mask sweep, R6 masking
    setup(8'h40, 0, 8'h00);
    pulse(8'hFF);
    for (int m = 0; m < 256; m++) begin
      wr(1'b1, 8'(m));
      chk("R6 masked int_req", int_req, (m != 255) ? 1 : 0);
      rd(1'b1, v); chk("R5 mask read", v, m);
    end

    // R8 vector base and empty acknowledge sweep
    for (int b = 0; b < 32; b++) begin
      setup(8'((b << 3) | (b & 7)), 0, 8'h00);
      ack(v); chk("R8 empty ack", v, (b << 3) | 7);
    end

    // R6 / R7 / R11 priority sweep over all bases and patterns
    for (int b = 0; b < 8; b++) begin
      for (int p = 0; p < 256; p++) begin
        int w;
        setup(8'h40, 0, 8'h00);
        wr(1'b0, 8'hC0 | 8'(b));
        pulse(8'(p));
        w = winner(8'(p), (b + 1) % 8);
        chk("R6 int_req", int_req, (p != 0) ? 1 : 0);
        rd(1'b0, v); chk("R6 pending latch", v, p);
        wr(1'b0, 8'h0C);
        rd(1'b0, v); chk("R7 poll value", v, w);
        rd(1'b0, v);
        chk("R7 poll clears", v, (p != 0) ? (p & ~(1 << w)) : 0);
      end
    end

    // R8 / R10 / R11 acknowledge and end-of-service commands
    setup(8'h40, 0, 8'h00);
    pulse(8'h28);
    chk("R6 raised", int_req, 1);
    ack(v); chk("R8 vector", v, 8'h43);
    chk("R6 blocked by service", int_req, 0);
    wr(1'b0, 8'h0B);
    rd(1'b0, v); chk("R5 service read", v, 8'h08);
    wr(1'b0, 8'h08);
    rd(1'b0, v); chk("R4 select kept", v, 8'h08);
    wr(1'b0, 8'h0A);
    rd(1'b0, v); chk("R4 select pending", v, 8'h20);
    wr(1'b0, 8'h0B);
    wr(1'b0, 8'h40);
    rd(1'b0, v); chk("R11 code2 nop", v, 8'h08);
    wr(1'b0, 8'h20);
    rd(1'b0, v); chk("R10 top clear", v, 8'h00);
    chk("R10 unblocked", int_req, 1);
    ack(v); chk("R8 second vector", v, 8'h45);
    rd(1'b0, v); chk("R8 service set", v, 8'h20);
    wr(1'b0, 8'h65);
    rd(1'b0, v); chk("R11 code3 line", v, 8'h00);
    pulse(8'h08);
    ack(v); chk("R8 line3", v, 8'h43);
    wr(1'b0, 8'hA0);
    rd(1'b0, v); chk("R10 code5 clear", v, 8'h00);
    pulse(8'h41);
    ack(v); chk("R10 code5 base", v, 8'h46);
    wr(1'b0, 8'hE6);
    rd(1'b0, v); chk("R11 code7 clear", v, 8'h00);
    pulse(8'h10);
    ack(v); chk("R11 code7 base", v, 8'h40);

    // R12 special mask
    setup(8'h40, 0, 8'h00);
    pulse(8'h02);
    ack(v); chk("R8 line1", v, 8'h41);
    pulse(8'h10);
    chk("R12 blocked before", int_req, 0);
    wr(1'b0, 8'h68);
    chk("R12 unblocked", int_req, 1);
    ack(v); chk("R12 vector", v, 8'h44);
    wr(1'b0, 8'h48);
    wr(1'b0, 8'h0B);
    rd(1'b0, v); chk("R12 service", v, 8'h12);

    // R13 cascade nesting
    setup(8'h40, 1, 8'h10);
    pulse(8'h04);
    ack(v); chk("R13 first ack", v, 8'h42);
    pulse(8'h04);
    chk("R13 nested raise", int_req, 1);
    setup(8'h40, 1, 8'h00);
    pulse(8'h04);
    ack(v);
    pulse(8'h04);
    chk("R13 plain blocked", int_req, 0);

    // R8 / R9 automatic end-of-service and rotation
    setup(8'h40, 1, 8'h02);
    pulse(8'h04);
    ack(v); chk("R8 auto vector", v, 8'h42);
    wr(1'b0, 8'h0B);
    rd(1'b0, v); chk("R8 auto no service", v, 8'h00);
    wr(1'b0, 8'h80);
    pulse(8'h04);
    ack(v); chk("R9 rotate ack", v, 8'h42);
    pulse(8'h12);
    ack(v); chk("R9 rotated winner", v, 8'h44);
    wr(1'b0, 8'h00);
    pulse(8'h40);
    ack(v); chk("R9 base 5 winner", v, 8'h46);
    pulse(8'h21);
    ack(v); chk("R9 no rotate", v, 8'h45);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule